// File: doc/BRIEF.md
# Interlace-Aware Scanout Address Generator

This block produces the word addresses used to read a picture window out of frame memory. It follows the display timing generator's window-active signal: every rising edge of that signal opens one active line, and the block then requests that line's words one after another over a request/ready handshake. A field-start pulse marks the beginning of each field. The next line that opens after that pulse takes a fresh snapshot of the window configuration and restarts from the field's start address.

There are two start addresses. One serves the long field and the other the short field. Line-to-line stepping is set by a separate modulo value, not by the line width. With a modulo of one, lines are packed back to back. In interlaced output the modulo is enlarged by one line's worth of words, so each field reads every other line of a progressive frame. In that case the short-field start usually sits one line after the long-field start, and the line count is set to half the frame height.

Top module: `scan_addr_gen`

## Requirements
- R1: While reset is held, and on the first cycles after it, `rd_req` is 0 and `rd_addr` is 0.
- R2: `win_size` packs three fields: bits 9:0 hold the words per line minus one, bits 19:10 hold the lines per field minus one, and bits 29:20 hold the modulo. Each opened line issues exactly (bits 9:0)+1 accepted requests, and `rd_req` is low in the cycle after the last word is accepted.
- R3: On the first rising edge of `win_active` after a `field_start` pulse, `rd_req` rises on the next cycle. The first address is `short_base` when `interlace`=1 and `field_odd`=1, and `long_base` in every other case.
- R4: The address moves up by one after each accepted request (`rd_req` and `rd_ready` both high). While `rd_ready` is low, `rd_req` and `rd_addr` hold their values.
- R5: Every later line of a field starts at the address of the previous line's last word plus the modulo. A modulo of 1 continues at the very next word.
- R6: A field ends after (bits 19:10)+1 lines. Further `win_active` rises produce no requests until the next `field_start`.
- R7: The start addresses and `win_size` are sampled only when a field's first line opens. Changes made during a field take effect from the next field.
- R8: A `win_active` rise that arrives while a line is still being fetched is ignored. It neither restarts nor extends that line.
- R9: A `field_start` pulse abandons any line in progress. `rd_req` is low in the next cycle.
- R10: `interlace` and `field_odd` are looked at only when a field's first line opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_start | input | 1 | One-cycle pulse at the start of each field |
| field_odd | input | 1 | 1 selects the short field (only when interlaced) |
| interlace | input | 1 | 1 enables short-field base selection |
| win_active | input | 1 | Window-active level from the timing generator; each rise opens a line |
| long_base | input | AW | Word address of the long field's first word |
| short_base | input | AW | Word address of the short field's first word |
| win_size | input | 30 | {modulo, lines-1, words-1}, 10 bits each |
| rd_ready | input | 1 | Memory side accepts the current request |
| rd_req | output | 1 | Read request valid |
| rd_addr | output | AW | Word address of the current request |

## Verification
A request is due one cycle after the clock edge that sees a `win_active` rise. After that, each accepted word moves `rd_addr` at the next edge, and after `field_start` the request drops at the next edge. The bench drives inputs on the falling edge and keeps a queue-based model. At each rising edge the model applies the same stimulus, and at the following falling edge it compares `rd_req` and `rd_addr` with the head of the queue. This places each comparison exactly one register stage after its cause. Word totals per scenario are also checked against counts worked out from the configured sizes.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam int FLD_W = 10;

  // Field order follows the bit positions of the size word (high to low).
  typedef struct packed {
    logic [FLD_W-1:0] modulo;
    logic [FLD_W-1:0] lines_m1;
    logic [FLD_W-1:0] words_m1;
  } win_cfg_t;

  localparam int CFG_W = $bits(win_cfg_t);

  function automatic logic pick_short(input logic ilace, input logic odd);
    return ilace & odd;
  endfunction
endpackage

// File: rtl/sag_field_ctl.sv
module sag_field_ctl
  import sag_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          field_start,
  input  logic          line_rise,
  input  logic          interlace,
  input  logic          field_odd,
  input  logic [AW-1:0] long_base,
  input  logic [AW-1:0] short_base,
  input  win_cfg_t      cfg_in,
  output logic          first_line,
  output logic [AW-1:0] base_sel,
  output win_cfg_t      cfg_q
);
  logic armed;

  assign first_line = line_rise & armed & ~field_start;
  assign base_sel   = pick_short(interlace, field_odd) ? short_base : long_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cfg_q <= '0;
    end else begin
      if (field_start)     armed <= 1'b1;
      else if (first_line) armed <= 1'b0;
      if (first_line)      cfg_q <= cfg_in;
    end
  end

  // R7: the snapshot only changes when a field's first line opens
  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !first_line |=> $stable(cfg_q));
endmodule

// File: rtl/sag_line_walk.sv
module sag_line_walk
  import sag_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          field_start,
  input  logic          line_rise,
  input  logic          first_line,
  input  logic [AW-1:0] base_sel,
  input  win_cfg_t      cfg,
  input  logic          rd_ready,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          line_end,
  output logic          field_end
);
  logic             busy, in_field;
  logic [AW-1:0]    addr, next_base;
  logic [FLD_W-1:0] word_cnt, line_cnt;
  logic             accept, resume;

  function automatic logic [AW-1:0] step_line(input logic [AW-1:0] last,
                                              input logic [FLD_W-1:0] modulo);
    return last + AW'(modulo);
  endfunction

  assign accept    = busy & rd_ready;
  assign line_end  = accept & (word_cnt == cfg.words_m1);
  assign field_end = line_end & (line_cnt == cfg.lines_m1);
  assign resume    = line_rise & ~busy & in_field & ~field_start & ~first_line;
  assign rd_req    = busy;
  assign rd_addr   = addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      in_field  <= 1'b0;
      addr      <= '0;
      next_base <= '0;
      word_cnt  <= '0;
      line_cnt  <= '0;
    end else if (field_start) begin
      busy     <= 1'b0;
      in_field <= 1'b0;
    end else if (first_line) begin
      busy     <= 1'b1;
      in_field <= 1'b1;
      addr     <= base_sel;
      word_cnt <= '0;
      line_cnt <= '0;
    end else if (resume) begin
      busy     <= 1'b1;
      addr     <= next_base;
      word_cnt <= '0;
    end else if (accept) begin
      if (line_end) begin
        busy      <= 1'b0;
        next_base <= step_line(addr, cfg.modulo);
        if (field_end) in_field <= 1'b0;
        else           line_cnt <= line_cnt + 1'b1;
      end else begin
        addr     <= addr + 1'b1;
        word_cnt <= word_cnt + 1'b1;
      end
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready && !field_start) |=> (rd_req && $stable(rd_addr)));
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !line_end && !field_start) |=> (rd_addr == $past(rd_addr) + 1'b1));
  assert_line_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !field_start) |=> !rd_req);
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> !rd_req);
  assert_no_rise_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rise && rd_req && !rd_ready && !field_start) |=> $stable(rd_addr));
endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
  import sag_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_start,
  input  logic             field_odd,
  input  logic             interlace,
  input  logic             win_active,
  input  logic [AW-1:0]    long_base,
  input  logic [AW-1:0]    short_base,
  input  logic [CFG_W-1:0] win_size,
  input  logic             rd_ready,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr
);
  logic          win_q, line_rise, first_line, line_end, field_end;
  logic [AW-1:0] base_sel;
  win_cfg_t      cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= win_active;
  end
  assign line_rise = win_active & ~win_q;

  sag_field_ctl #(.AW(AW)) u_field (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_rise(line_rise),
    .interlace(interlace), .field_odd(field_odd), .long_base(long_base),
    .short_base(short_base), .cfg_in(win_cfg_t'(win_size)),
    .first_line(first_line), .base_sel(base_sel), .cfg_q(cfg_q)
  );

  sag_line_walk #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_rise(line_rise),
    .first_line(first_line), .base_sel(base_sel), .cfg(cfg_q), .rd_ready(rd_ready),
    .rd_req(rd_req), .rd_addr(rd_addr), .line_end(line_end), .field_end(field_end)
  );

  assert_first_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
    first_line |=> (rd_req && rd_addr ==
      $past((interlace && field_odd) ? short_base : long_base)));
  assert_field_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (field_end && !field_start) |=> !rd_req);
endmodule

// File: tb/scan_addr_gen_test.sv
module scan_addr_gen_test;
  localparam int AW = 24;
  localparam int CW = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic field_start = 0, field_odd = 0, interlace = 0, win_active = 0, rd_ready = 1;
  logic [AW-1:0] long_base = '0, short_base = '0;
  logic [CW-1:0] win_size = '0;
  logic rd_req;
  logic [AW-1:0] rd_addr;

  int checks = 0, fails = 0, accepted = 0, ready_mode = 0;
  string cur_req = "R1";
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;  // 125 MHz

  scan_addr_gen #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .field_odd(field_odd),
    .interlace(interlace), .win_active(win_active), .long_base(long_base),
    .short_base(short_base), .win_size(win_size), .rd_ready(rd_ready),
    .rd_req(rd_req), .rd_addr(rd_addr)
  );

  function automatic logic [CW-1:0] size_word(int modv, int lines, int words);
    logic [CW-1:0] v;
    v = '0;
    v[29:20] = 10'(modv);
    v[19:10] = 10'(lines - 1);
    v[9:0]   = 10'(words - 1);
    return v;
  endfunction

  // behavioural reference model
  logic [AW-1:0] q[$];
  logic m_win = 0, m_armed = 0, m_infield = 0;
  logic [AW-1:0] m_next = '0;
  int m_words = 0, m_left = 0, m_mod = 0;

  task automatic push_line(logic [AW-1:0] start);
    for (int i = 0; i < m_words; i++) q.push_back(start + AW'(i));
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_win = 0; m_armed = 0; m_infield = 0;
    end else begin
      logic rise, busy_b;
      logic [AW-1:0] last;
      rise = win_active && !m_win;
      m_win = win_active;
      busy_b = q.size() > 0;
      if (field_start) begin
        q.delete(); m_armed = 1; m_infield = 0;
      end else if (busy_b && rd_ready) begin
        accepted++;
        last = q.pop_front();
        if (q.size() == 0) begin
          m_next = last + AW'(m_mod);
          m_left--;
          if (m_left == 0) m_infield = 0;
        end
      end else if (rise && !busy_b && m_armed) begin
        m_words = int'(win_size[9:0]) + 1;
        m_left  = int'(win_size[19:10]) + 1;
        m_mod   = int'(win_size[29:20]);
        m_armed = 0; m_infield = 1;
        push_line((interlace && field_odd) ? short_base : long_base);
      end else if (rise && !busy_b && m_infield) begin
        push_line(m_next);
      end
    end
  end

  task automatic check(logic ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic er;
      er = q.size() > 0;
      check(rd_req === er, cur_req, "rd_req", longint'(rd_req), longint'(er));
      if (er) check(rd_addr === q[0], cur_req, "rd_addr", longint'(rd_addr), longint'(q[0]));
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? lfsr[0] : 1'b0;
  end

  task automatic new_field();
    @(negedge clk) field_start = 1;
    @(negedge clk) field_start = 0;
  endtask

  task automatic open_line(int hi, int lo);
    @(negedge clk) win_active = 1;
    repeat (hi) @(negedge clk);
    win_active = 0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R6: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int base_cnt;
    repeat (3) @(negedge clk);
    check(rd_req === 1'b0, "R1", "reset req", longint'(rd_req), 0);
    check(rd_addr === '0, "R1", "reset addr", longint'(rd_addr), 0);
    rst_n = 1;
    @(negedge clk);
    check(rd_req === 1'b0, "R1", "post-reset req", longint'(rd_req), 0);

    // R2 R5 R6: progressive, 4 words x 3 lines, packed lines
    cur_req = "R5";
    long_base = 24'h000100; short_base = 24'h000800;
    win_size = size_word(1, 3, 4);
    new_field();
    base_cnt = accepted;
    @(negedge clk) win_active = 1;
    @(negedge clk);
    check(rd_req === 1'b1 && rd_addr === 24'h100, "R3", "first word long base",
          longint'(rd_addr), 24'h100);
    win_active = 0;
    repeat (20) @(negedge clk);
    open_line(2, 20);
    open_line(2, 20);
    cur_req = "R6";
    open_line(2, 20);
    check(accepted - base_cnt == 12, "R6", "words per field", accepted - base_cnt, 12);
    check(rd_req === 1'b0, "R6", "quiet after field", longint'(rd_req), 0);

    // R4: random stalls, R7: mid-field changes ignored
    cur_req = "R4";
    ready_mode = 1;
    new_field();
    base_cnt = accepted;
    open_line(2, 40);
    cur_req = "R7";
    win_size = size_word(2, 2, 8);
    long_base = 24'h000500;
    open_line(2, 40);
    open_line(2, 40);
    check(accepted - base_cnt == 12, "R7", "old size kept", accepted - base_cnt, 12);
    check(accepted - base_cnt == 12, "R2", "width from bits 9:0", accepted - base_cnt, 12);
    new_field();
    base_cnt = accepted;
    open_line(2, 60);
    open_line(2, 60);
    open_line(2, 60);
    check(accepted - base_cnt == 16, "R7", "new size next field", accepted - base_cnt, 16);
    ready_mode = 0;

    // R3 R5: interlaced short field with line-skipping modulo
    cur_req = "R3";
    interlace = 1; field_odd = 1;
    win_size = size_word(5, 2, 4);
    new_field();
    base_cnt = accepted;
    @(negedge clk) win_active = 1;
    @(negedge clk);
    check(rd_addr === 24'h800, "R3", "short base", longint'(rd_addr), 24'h800);
    win_active = 0;
    repeat (20) @(negedge clk);
    @(negedge clk) win_active = 1;
    @(negedge clk);
    check(rd_addr === 24'h808, "R5", "modulo skip", longint'(rd_addr), 24'h808);
    win_active = 0;
    repeat (20) @(negedge clk);

    // R10: polarity combinations
    cur_req = "R10";
    field_odd = 0;
    new_field();
    @(negedge clk) win_active = 1;
    @(negedge clk);
    check(rd_addr === 24'h500, "R10", "interlaced even uses long", longint'(rd_addr), 24'h500);
    field_odd = 1;
    win_active = 0;
    repeat (20) @(negedge clk);
    interlace = 0;
    new_field();
    @(negedge clk) win_active = 1;
    @(negedge clk);
    check(rd_addr === 24'h500, "R10", "progressive odd uses long", longint'(rd_addr), 24'h500);
    win_active = 0;
    repeat (20) @(negedge clk);

    // R8: rise while a line is stalled
    cur_req = "R8";
    win_size = size_word(1, 4, 4);
    new_field();
    base_cnt = accepted;
    ready_mode = 2;
    @(negedge clk) win_active = 1;
    @(negedge clk) win_active = 0;
    @(negedge clk) win_active = 1;
    repeat (3) @(negedge clk);
    check(rd_addr === 24'h500, "R8", "no restart", longint'(rd_addr), 24'h500);
    ready_mode = 0;
    win_active = 0;
    repeat (20) @(negedge clk);
    check(accepted - base_cnt == 4, "R8", "single line words", accepted - base_cnt, 4);

    // R9: field start aborts a stalled line
    cur_req = "R9";
    ready_mode = 2;
    open_line(1, 3);
    new_field();
    @(negedge clk);
    check(rd_req === 1'b0, "R9", "abort", longint'(rd_req), 0);
    ready_mode = 0;
    repeat (10) @(negedge clk);

    summary();
    $finish;
  end
endmodule